// File: doc/BRIEF.md
# Four-Line Configurable Pin Controller

This block manages four general-purpose pad lines on behalf of a serial slave device. It decodes a small window of the slave's byte-wide memory bus and exposes two volatile configuration registers, two reserved read-only bytes and one access register per line. Each line can be an input or an output. An output drives either push-pull or open-drain, and its readback can be inverted.

The power-on setup comes from two stored default bytes presented on input ports. After the reset release has passed a two-flop synchronizer, the block copies those bytes into its volatile registers in one clock cycle. All pads stay undriven until the copy is done. From then on, software writes on the bus can change every setting. Pad inputs pass through a synchronizer before they reach the read path. Addresses outside the window read as 00h, so the read data can be OR-combined with the rest of the memory map.

Top module: `pio_ctrl_top`

## Requirements
- R1: While reset is asserted, and until the default copy completes (three clock edges after `rst_n` rises), every `pad_oe` bit is 0.
- R2: After the copy, the state is set from the stored bytes: direction = `dflt_a[3:0]` (1 = output), output latch = `dflt_a[7:4]`, output type = `dflt_b[3:0]` (1 = open-drain), read inversion = `dflt_b[7:4]`, and control nibble = 0. Bit i of each nibble belongs to line i.
- R3: A write to 7Ah sets direction from `wdata[3:0]` and the control nibble from `wdata[7:4]`. Reading 7Ah returns {control, direction}.
- R4: A write to 7Bh sets output type from `wdata[3:0]` and inversion from `wdata[7:4]`. Reading 7Bh returns {inversion, type}.
- R5: A push-pull output line has `pad_oe`=1 and `pad_out` equal to its latch bit.
- R6: An open-drain output line drives low (`pad_oe`=1, `pad_out`=0) when its latch is 0, and releases (`pad_oe`=0) when its latch is 1.
- R7: An input line has `pad_oe`=0.
- R8: Reading 7Ch+i returns, in bit 0, the synchronized level of `pad_in[i]` XOR inversion bit i. Bits 7:1 are 0. A pad change is visible after two clock edges.
- R9: A write to 7Ch+i loads `wdata[0]` into latch i only when line i is an output. Otherwise the latch keeps its value.
- R10: Addresses 78h and 79h read FFh, and writes to them change nothing.
- R11: Any other address reads 00h, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dflt_a | input | 8 | Stored default: {latch, direction} |
| dflt_b | input | 8 | Stored default: {inversion, output type} |
| bus_addr | input | 8 | Byte address within the slave memory map |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pad_in | input | 4 | Pad input levels |
| pad_out | output | 4 | Pad output values |
| pad_oe | output | 4 | Pad output enables |

## Verification
Register reads are combinational, so a read is sampled a moment after the address is set in the same cycle. Writes take effect at the next clock edge, and pad drive follows combinationally from the registers. A pad input reaches the read path two edges after it changes. The default copy lands on the third edge after reset release. The bench drives inputs at falling edges, waits three falling edges after every operation before it checks the whole register window and all pads, and checks pad enables directly on the first two falling edges after reset release.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int NPIO = 4;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] ADR_RESV0    = 8'h78;
  localparam logic [BYTE_W-1:0] ADR_RESV1    = 8'h79;
  localparam logic [BYTE_W-1:0] ADR_CFG_DIR  = 8'h7A;
  localparam logic [BYTE_W-1:0] ADR_CFG_DRV  = 8'h7B;
  localparam logic [BYTE_W-1:0] ADR_ACC_BASE = 8'h7C;

  typedef struct packed {
    logic [3:0]      ctrl;
    logic [NPIO-1:0] dir;
    logic [NPIO-1:0] otype;
    logic [NPIO-1:0] inv;
    logic [NPIO-1:0] latch;
  } pio_cfg_t;
endpackage

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] dflt_a,
  input  logic [BYTE_W-1:0] dflt_b,
  input  logic              wr,
  input  logic [BYTE_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output pio_cfg_t          cfg,
  output logic              init_done
);
  pio_cfg_t cfg_q, cfg_d;
  logic     init_q, init_d;
  logic     upd_en;

  assign upd_en = !init_q || wr;

  always_comb begin
    cfg_d  = cfg_q;
    init_d = init_q;
    if (!init_q) begin
      cfg_d.dir   = dflt_a[NPIO-1:0];
      cfg_d.latch = dflt_a[BYTE_W-1:NPIO];
      cfg_d.otype = dflt_b[NPIO-1:0];
      cfg_d.inv   = dflt_b[BYTE_W-1:NPIO];
      cfg_d.ctrl  = '0;
      init_d      = 1'b1;
    end else if (wr) begin
      if (addr == ADR_CFG_DIR) begin
        cfg_d.dir  = wdata[NPIO-1:0];
        cfg_d.ctrl = wdata[BYTE_W-1:NPIO];
      end else if (addr == ADR_CFG_DRV) begin
        cfg_d.otype = wdata[NPIO-1:0];
        cfg_d.inv   = wdata[BYTE_W-1:NPIO];
      end else begin
        for (int i = 0; i < NPIO; i++) begin
          if (addr == ADR_ACC_BASE + 8'(i) && cfg_q.dir[i]) cfg_d.latch[i] = wdata[0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      init_q <= 1'b0;
    end else if (upd_en) begin
      cfg_q  <= cfg_d;
      init_q <= init_d;
    end
  end

  assign cfg       = cfg_q;
  assign init_done = init_q;

  assert_load_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_q) |-> (cfg_q.dir == $past(dflt_a[NPIO-1:0]) && cfg_q.ctrl == 4'h0));

  assert_resv_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q && wr && (addr == ADR_RESV0 || addr == ADR_RESV1)) |=> $stable(cfg_q));

  for (genvar g = 0; g < NPIO; g++) begin : g_latch_chk
    assert_input_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (init_q && wr && addr == ADR_ACC_BASE + 8'(g) && !cfg_q.dir[g]) |=> $stable(cfg_q.latch[g]));
  end
endmodule

// File: rtl/pio_pin.sv
module pio_pin #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_done,
  input  logic dir,
  input  logic otype,
  input  logic latch,
  input  logic pad_in,
  output logic pad_oe,
  output logic pad_out,
  output logic level
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pad_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign level = sync_q[SYNC_STAGES-1];

  always_comb begin
    pad_oe  = 1'b0;
    pad_out = 1'b0;
    if (init_done && dir) begin
      if (otype) begin
        pad_oe = !latch;
      end else begin
        pad_oe  = 1'b1;
        pad_out = latch;
      end
    end
  end

  assert_quiet_before_init_R1: assert property (@(posedge clk)
    !init_done |-> !pad_oe);

  assert_od_no_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (otype && pad_oe) |-> !pad_out);

  assert_input_undriven_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dir |-> !pad_oe);
endmodule

// File: rtl/pio_rdmux.sv
module pio_rdmux
  import pio_pkg::*;
(
  input  logic [BYTE_W-1:0] addr,
  input  pio_cfg_t          cfg,
  input  logic [NPIO-1:0]   level,
  output logic [BYTE_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (addr == ADR_RESV0 || addr == ADR_RESV1) begin
      rdata = '1;
    end else if (addr == ADR_CFG_DIR) begin
      rdata = {cfg.ctrl, cfg.dir};
    end else if (addr == ADR_CFG_DRV) begin
      rdata = {cfg.inv, cfg.otype};
    end else begin
      for (int i = 0; i < NPIO; i++) begin
        if (addr == ADR_ACC_BASE + 8'(i)) rdata = {7'b0, level[i] ^ cfg.inv[i]};
      end
    end
  end
endmodule

// File: rtl/pio_ctrl_top.sv
module pio_ctrl_top
  import pio_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              dflt_a,
  input  logic [7:0]              dflt_b,
  input  logic [7:0]              bus_addr,
  input  logic                    bus_wr,
  input  logic [7:0]              bus_wdata,
  output logic [7:0]              bus_rdata,
  input  logic [3:0]              pad_in,
  output logic [3:0]              pad_out,
  output logic [3:0]              pad_oe
);
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_s_n;
  pio_cfg_t              cfg;
  logic                  init_done;
  logic [NPIO-1:0]       level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[RST_STAGES-1];

  pio_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .dflt_a    (dflt_a),
    .dflt_b    (dflt_b),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .cfg       (cfg),
    .init_done (init_done)
  );

  for (genvar g = 0; g < NPIO; g++) begin : g_pin
    pio_pin #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
      .clk       (clk),
      .rst_n     (rst_s_n),
      .init_done (init_done),
      .dir       (cfg.dir[g]),
      .otype     (cfg.otype[g]),
      .latch     (cfg.latch[g]),
      .pad_in    (pad_in[g]),
      .pad_oe    (pad_oe[g]),
      .pad_out   (pad_out[g]),
      .level     (level[g])
    );
  end

  pio_rdmux u_rdmux (
    .addr  (bus_addr),
    .cfg   (cfg),
    .level (level),
    .rdata (bus_rdata)
  );

  assert_resv_read_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_addr == ADR_RESV0 || bus_addr == ADR_RESV1) |-> bus_rdata == 8'hFF);

  assert_acc_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_addr >= ADR_ACC_BASE && bus_addr < ADR_ACC_BASE + 8'(NPIO)) |-> bus_rdata[7:1] == 7'h0);

  assert_out_of_window_R11: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_addr < ADR_RESV0 || bus_addr >= ADR_ACC_BASE + 8'(NPIO)) |-> bus_rdata == 8'h00);
endmodule

// File: tb/tb_pio_ctrl_top.sv
module tb_pio_ctrl_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] dflt_a = 8'hA7;
  logic [7:0] dflt_b = 8'h94;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [3:0] pad_in;
  logic [3:0] pad_out;
  logic [3:0] pad_oe;
  logic [3:0] ext = 4'b0101;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [3:0] m_dir, m_ctrl, m_typ, m_inv, m_lat;

  always #5 clk = ~clk;

  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  pio_ctrl_top dut (
    .clk(clk), .rst_n(rst_n), .dflt_a(dflt_a), .dflt_b(dflt_b),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic logic [3:0] exp_oe();
    logic [3:0] r;
    for (int i = 0; i < 4; i++)
      r[i] = m_dir[i] && (m_typ[i] ? !m_lat[i] : 1'b1);
    return r;
  endfunction

  function automatic logic [3:0] exp_out();
    logic [3:0] r;
    for (int i = 0; i < 4; i++)
      r[i] = m_dir[i] && !m_typ[i] && m_lat[i];
    return r;
  endfunction

  function automatic logic [3:0] exp_level();
    logic [3:0] oe, out;
    oe = exp_oe();
    out = exp_out();
    return (oe & out) | (~oe & ext);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [7:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic check_all();
    logic [3:0] lv;
    lv = exp_level();
    chk("R5/R6/R7 pad_oe", {4'h0, pad_oe}, {4'h0, exp_oe()});
    chk("R5/R6 pad_out", {4'h0, pad_out & pad_oe}, {4'h0, exp_out() & exp_oe()});
    rd_chk("R3 read 7Ah", 8'h7A, {m_ctrl, m_dir});
    rd_chk("R4 read 7Bh", 8'h7B, {m_inv, m_typ});
    rd_chk("R10 read 78h", 8'h78, 8'hFF);
    rd_chk("R10 read 79h", 8'h79, 8'hFF);
    for (int i = 0; i < 4; i++)
      rd_chk("R8 access read", 8'h7C + 8'(i), {7'h0, lv[i] ^ m_inv[i]});
    rd_chk("R11 read 40h", 8'h40, 8'h00);
    rd_chk("R11 read 76h", 8'h76, 8'h00);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic do_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 8'h7A) begin m_dir = d[3:0]; m_ctrl = d[7:4]; end
    else if (a == 8'h7B) begin m_typ = d[3:0]; m_inv = d[7:4]; end
    else if (a >= 8'h7C && a <= 8'h7F) begin
      if (m_dir[a[1:0]]) m_lat[a[1:0]] = d[0];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    m_dir = dflt_a[3:0]; m_lat = dflt_a[7:4];
    m_typ = dflt_b[3:0]; m_inv = dflt_b[7:4]; m_ctrl = 4'h0;

    repeat (3) @(negedge clk);
    chk("R1 oe in reset", {4'h0, pad_oe}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe 1 edge after release", {4'h0, pad_oe}, 8'h00);
    @(negedge clk);
    chk("R1 oe 2 edges after release", {4'h0, pad_oe}, 8'h00);
    @(negedge clk);
    chk("R2 oe after load", {4'h0, pad_oe}, 8'h07);
    chk("R2 out after load", {4'h0, pad_out}, 8'h02);
    settle();
    rd_chk("R2 defaults dir", 8'h7A, 8'h07);
    rd_chk("R2 defaults drv", 8'h7B, 8'h94);
    check_all();

    // R9: line 3 is an input with latch 1; a write of 0 must not land
    do_write(8'h7F, 8'h00);
    do_write(8'h7B, 8'h00);
    do_write(8'h7A, 8'h0F);
    settle();
    chk("R9 ignored latch write on input", {4'h0, pad_out}, {4'h0, 1'b1, 1'b0, 1'b1, 1'b0});
    check_all();

    // R6: open-drain release and drive-low on line 0
    do_write(8'h7B, 8'h01);
    do_write(8'h7C, 8'h01);
    settle();
    chk("R6 od released", {7'h0, pad_oe[0]}, 8'h00);
    do_write(8'h7C, 8'h00);
    settle();
    chk("R6 od drive low", {6'h0, pad_oe[0], pad_out[0]}, 8'h02);

    // R10/R11: writes outside the live registers
    do_write(8'h78, 8'hFF);
    do_write(8'h79, 8'h00);
    do_write(8'h40, 8'hFF);
    settle();
    check_all();

    for (int n = 0; n < 250; n++) begin
      int unsigned r;
      r = $urandom % 10;
      case (r)
        0, 1: do_write(8'h7A, 8'($urandom));
        2:    do_write(8'h7B, 8'($urandom));
        3, 4, 5, 6: do_write(8'h7C + 8'($urandom % 4), 8'($urandom));
        7:    do_write(8'h78 + 8'($urandom % 2), 8'($urandom));
        8:    do_write(8'($urandom % 8'h78), 8'($urandom));
        default: begin @(negedge clk); ext = 4'($urandom); end
      endcase
      settle();
      check_all();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule